// File: doc/BRIEF.md
# Internal Data Memory Unit

This block holds the 256-byte on-chip scratch RAM of an 8051-class core. It serves the core's four data-access styles. A direct byte access uses a literal address. An indirect byte access goes through a pointer register. A register access reaches R0..R7 of the active bank. A single-bit access lands in the bit-addressable byte window. The core gives the access style, an 8-bit operand, a write flag, write data and the two bank-select bits from its status word. The block returns read data with a valid pulse.

One address range does two jobs. A direct access to 0x80..0xFF leaves the RAM and goes out on a special-function-register port. An indirect access to the same numbers reaches the physically separate upper 128 RAM bytes. Bit operands from 0x00 to 0x7F select single bits of bytes 0x20..0x2F. A bit write there is done as read-modify-write. Bit operands from 0x80 upward are sent to the register port with a bit index. Indirect accesses and RAM bit writes take a second cycle, and `busy` is high during that cycle.

Top module: `idata_unit`

## Requirements
- R1: Access kind is coded on `req_kind` as 0 = direct, 1 = indirect, 2 = register, 3 = bit. A direct access with operand below 0x80 reads or writes the RAM byte at that operand.
- R2: A direct access with operand 0x80..0xFF does not touch RAM. It raises `sfr_re` (read) or `sfr_we` (write) for the acceptance cycle, with `sfr_addr` equal to the operand and `sfr_bit_en` low. A read returns the `sfr_rdata` byte sampled in that cycle.
- R3: An indirect access uses operand bit 0 to pick R0 or R1 of the active bank as pointer. It reads or writes the RAM byte at the full 8-bit pointer value, so pointers of 0x80 and above reach upper RAM and never the register port. `busy` is high for exactly the one cycle after acceptance.
- R4: A register access to Rn (n = operand bits 2:0) reaches RAM byte bank*8 + n. The bank is `psw_bank`, bit 1 = RS1 and bit 0 = RS0, sampled in the acceptance cycle.
- R5: A bit read with operand b below 0x80 returns bit b[2:0] of RAM byte 0x20 + (b >> 3), zero-extended. RAM byte b itself is not involved.
- R6: A bit write with operand below 0x80 replaces only the target bit with `req_wdata[0]`. `busy` is high for the one cycle after acceptance, and the other seven bits of that byte are unchanged.
- R7: A bit access with operand b of 0x80 or above drives the register port with `sfr_addr` = b & 0xF8, `sfr_bit_en` high and `sfr_bit_idx` = b[2:0]. A write sends `req_wdata[0]` in bit 0 of `sfr_wdata`. A read returns bit b[2:0] of `sfr_rdata`, zero-extended.
- R8: A request is accepted only when `busy` is low. A request presented while `busy` is high has no effect on RAM or the register port.
- R9: While `rst` is high, and in the cycle after it, `busy` and `rsp_valid` are low.
- R10: Each read gives exactly one `rsp_valid` pulse. It comes one cycle after acceptance, or two cycles after for indirect reads. Writes give none.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | Access kind: 0 direct, 1 indirect, 2 register, 3 bit |
| req_addr | input | 8 | Byte address, register number, pointer select or bit address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write data (bit 0 only for bit writes) |
| psw_bank | input | 2 | Active register bank {RS1,RS0} |
| busy | output | 1 | Second cycle of a two-cycle access; requests ignored |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 8 | Read data |
| sfr_re | output | 1 | Register-port read strobe |
| sfr_we | output | 1 | Register-port write strobe |
| sfr_addr | output | 8 | Register-port byte address |
| sfr_wdata | output | 8 | Register-port write data |
| sfr_bit_en | output | 1 | Register-port access is a single-bit access |
| sfr_bit_idx | output | 3 | Bit position for a single-bit register-port access |
| sfr_rdata | input | 8 | Register-port read data, valid in the strobe cycle |

## Verification
Some rules are checked by assertions on every cycle. A port strobe never coincides with a RAM write. A second-cycle state lasts one cycle. Nothing is accepted while busy. Every non-indirect read is followed by a valid pulse, and a decoded bit address never leaves the bit window. The other rules only show up in the bench's access sequence against its model. These are the bank arithmetic across bank changes, the separation of upper RAM from the register space at equal addresses, the preservation of neighbouring bits in a read-modify-write, and bit-versus-byte aliasing of one operand value.

// File: rtl/idata_pkg.sv
package idata_pkg;
  typedef enum logic [1:0] {
    ACC_DIRECT   = 2'd0,
    ACC_INDIRECT = 2'd1,
    ACC_REGISTER = 2'd2,
    ACC_BIT      = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    SRC_RAM_BYTE = 2'd0,
    SRC_RAM_BIT  = 2'd1,
    SRC_SFR_BYTE = 2'd2,
    SRC_SFR_BIT  = 2'd3
  } rsp_src_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PTR  = 2'd1,
    ST_RMW  = 2'd2
  } fsm_e;
endpackage

// File: rtl/idata_ram.sv
module idata_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // single port, read-before-write, one cycle read latency
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    q <= mem[addr];
  end
endmodule

// File: rtl/idata_decode.sv
module idata_decode
  import idata_pkg::*;
#(
  parameter int            AW       = 8,
  parameter int            DW       = 8,
  parameter int            BANK_W   = 2,
  parameter int            REG_W    = 3,
  parameter logic [AW-1:0] BIT_BASE = 8'h20
) (
  input  acc_kind_e               kind,
  input  logic [AW-1:0]           operand,
  input  logic [BANK_W-1:0]       bank,
  output logic                    to_sfr,
  output logic [AW-1:0]           tgt_addr,
  output logic [$clog2(DW)-1:0]   bit_idx
);
  localparam int BIDX_W   = $clog2(DW);
  localparam int PAD_W    = AW - BANK_W - REG_W;
  localparam int WIN_SIZE = 1 << (AW - 1 - BIDX_W);

  logic upper;
  assign upper   = operand[AW-1];
  assign bit_idx = operand[BIDX_W-1:0];

  always_comb begin
    to_sfr   = 1'b0;
    tgt_addr = operand;
    unique case (kind)
      ACC_DIRECT: begin
        to_sfr   = upper;
        tgt_addr = operand;
      end
      ACC_INDIRECT: begin
        tgt_addr = {{PAD_W{1'b0}}, bank, {(REG_W-1){1'b0}}, operand[0]};
      end
      ACC_REGISTER: begin
        tgt_addr = {{PAD_W{1'b0}}, bank, operand[REG_W-1:0]};
      end
      ACC_BIT: begin
        to_sfr = upper;
        if (upper) tgt_addr = {operand[AW-1:BIDX_W], {BIDX_W{1'b0}}};
        else       tgt_addr = BIT_BASE + AW'(operand[AW-2:BIDX_W]);
      end
      default: ;
    endcase
  end

  // R5: a RAM bit operand always lands inside the bit window
  always_comb begin
    if (kind == ACC_BIT && !upper) begin
      p_bit_window_r5: assert (tgt_addr >= BIT_BASE &&
                               tgt_addr < BIT_BASE + AW'(WIN_SIZE));
    end
  end
endmodule

// File: rtl/idata_unit.sv
module idata_unit
  import idata_pkg::*;
#(
  parameter int            AW       = 8,
  parameter int            DW       = 8,
  parameter int            BANK_W   = 2,
  parameter int            REG_W    = 3,
  parameter logic [AW-1:0] BIT_BASE = 8'h20
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic [1:0]            req_kind,
  input  logic [AW-1:0]         req_addr,
  input  logic                  req_we,
  input  logic [DW-1:0]         req_wdata,
  input  logic [BANK_W-1:0]     psw_bank,
  output logic                  busy,
  output logic                  rsp_valid,
  output logic [DW-1:0]         rsp_rdata,
  output logic                  sfr_re,
  output logic                  sfr_we,
  output logic [AW-1:0]         sfr_addr,
  output logic [DW-1:0]         sfr_wdata,
  output logic                  sfr_bit_en,
  output logic [$clog2(DW)-1:0] sfr_bit_idx,
  input  logic [DW-1:0]         sfr_rdata
);
  localparam int BIDX_W = $clog2(DW);

  fsm_e              state;
  acc_kind_e         kind;
  logic              accept;
  logic              is_bit;
  logic              d_sfr;
  logic [AW-1:0]     d_addr;
  logic [BIDX_W-1:0] d_idx;

  logic [AW-1:0]     ram_a;
  logic              ram_we;
  logic [DW-1:0]     ram_wd;
  logic [DW-1:0]     ram_q;
  logic [DW-1:0]     merged;

  logic              pend_we;
  logic [DW-1:0]     pend_wd;
  logic [AW-1:0]     pend_addr;
  logic [BIDX_W-1:0] pend_idx;
  logic              pend_bit;
  rsp_src_e          rsp_src;
  logic [BIDX_W-1:0] rsp_idx;
  logic [DW-1:0]     sfr_q;

  assign kind   = acc_kind_e'(req_kind);
  assign busy   = (state != ST_IDLE);
  assign accept = req_valid && (state == ST_IDLE);
  assign is_bit = (kind == ACC_BIT);

  idata_decode #(
    .AW(AW), .DW(DW), .BANK_W(BANK_W), .REG_W(REG_W), .BIT_BASE(BIT_BASE)
  ) u_decode (
    .kind     (kind),
    .operand  (req_addr),
    .bank     (psw_bank),
    .to_sfr   (d_sfr),
    .tgt_addr (d_addr),
    .bit_idx  (d_idx)
  );

  idata_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk   (clk),
    .addr  (ram_a),
    .we    (ram_we),
    .wdata (ram_wd),
    .q     (ram_q)
  );

  // read-modify-write merge: only the addressed bit changes
  always_comb begin
    merged           = ram_q;
    merged[pend_idx] = pend_bit;
  end

  always_comb begin
    unique case (state)
      ST_PTR: begin
        ram_a  = ram_q;
        ram_we = pend_we;
        ram_wd = pend_wd;
      end
      ST_RMW: begin
        ram_a  = pend_addr;
        ram_we = 1'b1;
        ram_wd = merged;
      end
      default: begin
        ram_a  = d_addr;
        ram_we = accept && req_we && !d_sfr &&
                 (kind == ACC_DIRECT || kind == ACC_REGISTER);
        ram_wd = req_wdata;
      end
    endcase
  end

  assign sfr_re      = accept && d_sfr && !req_we;
  assign sfr_we      = accept && d_sfr && req_we;
  assign sfr_addr    = d_addr;
  assign sfr_bit_en  = accept && d_sfr && is_bit;
  assign sfr_bit_idx = d_idx;
  assign sfr_wdata   = is_bit ? {{(DW-1){1'b0}}, req_wdata[0]} : req_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            if (kind == ACC_INDIRECT)               state <= ST_PTR;
            else if (is_bit && !d_sfr && req_we)    state <= ST_RMW;
            if (!req_we && kind != ACC_INDIRECT)    rsp_valid <= 1'b1;
          end
        end
        ST_PTR: begin
          state <= ST_IDLE;
          if (!pend_we) rsp_valid <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      pend_we   <= req_we;
      pend_wd   <= req_wdata;
      pend_addr <= d_addr;
      pend_idx  <= d_idx;
      pend_bit  <= req_wdata[0];
      rsp_idx   <= d_idx;
      sfr_q     <= sfr_rdata;
      if (d_sfr) rsp_src <= is_bit ? SRC_SFR_BIT : SRC_SFR_BYTE;
      else       rsp_src <= is_bit ? SRC_RAM_BIT : SRC_RAM_BYTE;
    end else if (state == ST_PTR) begin
      rsp_src <= SRC_RAM_BYTE;
    end
  end

  always_comb begin
    rsp_rdata = '0;
    if (rsp_valid) begin
      unique case (rsp_src)
        SRC_RAM_BYTE: rsp_rdata = ram_q;
        SRC_RAM_BIT:  rsp_rdata = {{(DW-1){1'b0}}, ram_q[rsp_idx]};
        SRC_SFR_BYTE: rsp_rdata = sfr_q;
        default:      rsp_rdata = {{(DW-1){1'b0}}, sfr_q[rsp_idx]};
      endcase
    end
  end

  // R2: a register-port strobe never coincides with a RAM write
  p_sfr_no_ram_r2: assert property (@(posedge clk) disable iff (rst)
    (sfr_re || sfr_we) |-> !ram_we);

  // R3: an accepted indirect access is busy in the next cycle
  p_ptr_busy_r3: assert property (@(posedge clk) disable iff (rst)
    (accept && kind == ACC_INDIRECT) |=> busy);

  // R6: a second-cycle state lasts exactly one cycle
  p_busy_single_r6: assert property (@(posedge clk) disable iff (rst)
    busy |=> !busy);

  // R8: nothing reaches the register port while busy
  p_no_accept_busy_r8: assert property (@(posedge clk) disable iff (rst)
    busy |-> !(sfr_re || sfr_we));

  // R9: reset clears the control state
  p_reset_idle_r9: assert property (@(posedge clk)
    rst |=> (!busy && !rsp_valid));

  // R10: a non-indirect read answers in the following cycle
  p_rsp_next_r10: assert property (@(posedge clk) disable iff (rst)
    (accept && !req_we && kind != ACC_INDIRECT) |=> rsp_valid);
endmodule

// File: tb/idata_unit_bench.sv
`timescale 1ns/1ps
module idata_unit_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       req_valid;
  logic [1:0] req_kind;
  logic [7:0] req_addr;
  logic       req_we;
  logic [7:0] req_wdata;
  logic [1:0] psw_bank;
  logic       busy;
  logic       rsp_valid;
  logic [7:0] rsp_rdata;
  logic       sfr_re;
  logic       sfr_we;
  logic [7:0] sfr_addr;
  logic [7:0] sfr_wdata;
  logic       sfr_bit_en;
  logic [2:0] sfr_bit_idx;
  logic [7:0] sfr_rdata;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  idata_unit u_idata_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .psw_bank(psw_bank), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .sfr_re(sfr_re), .sfr_we(sfr_we),
    .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_bit_en(sfr_bit_en),
    .sfr_bit_idx(sfr_bit_idx), .sfr_rdata(sfr_rdata)
  );

  // behavioural register-port model
  logic [7:0] sfr_mem [256];
  initial for (int i = 0; i < 256; i++) sfr_mem[i] = 8'h00;
  assign sfr_rdata = sfr_mem[sfr_addr];
  always @(posedge clk) begin
    if (sfr_we) begin
      if (sfr_bit_en) sfr_mem[sfr_addr][sfr_bit_idx] <= sfr_wdata[0];
      else            sfr_mem[sfr_addr] <= sfr_wdata;
    end
  end

  // {kind[2], we, bank[2], operand[8], wdata[8], expected[8]}
  localparam int NV = 34;
  localparam logic [28:0] VEC [NV] = '{
    {2'd0,1'b1,2'd0,8'h05,8'hA5,8'h00}, // R1 direct write
    {2'd0,1'b1,2'd0,8'h00,8'h11,8'h00}, // R1
    {2'd0,1'b1,2'd0,8'h22,8'hF0,8'h00}, // R1
    {2'd0,1'b1,2'd0,8'h13,8'hC3,8'h00}, // R1 byte 0x13 for alias check
    {2'd2,1'b0,2'd0,8'h05,8'h00,8'hA5}, // R4 bank0 R5
    {2'd2,1'b1,2'd1,8'h00,8'h5A,8'h00}, // R4 bank1 R0 = 0x08
    {2'd2,1'b0,2'd0,8'h00,8'h00,8'h11}, // R4 bank switch back
    {2'd0,1'b0,2'd0,8'h08,8'h00,8'h5A}, // R4 via direct
    {2'd2,1'b1,2'd2,8'h00,8'h90,8'h00}, // R4 bank2 R0 = 0x90
    {2'd0,1'b0,2'd0,8'h10,8'h00,8'h90}, // R1
    {2'd1,1'b1,2'd2,8'h00,8'h3C,8'h00}, // R3 upper RAM 0x90
    {2'd0,1'b0,2'd0,8'h90,8'h00,8'h00}, // R2 port untouched
    {2'd1,1'b0,2'd2,8'h00,8'h00,8'h3C}, // R3
    {2'd0,1'b1,2'd0,8'h90,8'h77,8'h00}, // R2 port write
    {2'd0,1'b0,2'd0,8'h90,8'h00,8'h77}, // R2
    {2'd1,1'b0,2'd2,8'h00,8'h00,8'h3C}, // R3 upper RAM kept
    {2'd3,1'b1,2'd0,8'h13,8'h01,8'h00}, // R6 set bit3 of 0x22
    {2'd0,1'b0,2'd0,8'h22,8'h00,8'hF8}, // R6
    {2'd3,1'b0,2'd0,8'h13,8'h00,8'h01}, // R5
    {2'd3,1'b1,2'd0,8'h17,8'h00,8'h00}, // R6 clear bit7
    {2'd0,1'b0,2'd0,8'h22,8'h00,8'h78}, // R6
    {2'd3,1'b0,2'd0,8'h14,8'h00,8'h01}, // R5
    {2'd3,1'b0,2'd0,8'h12,8'h00,8'h00}, // R5
    {2'd3,1'b1,2'd0,8'h93,8'h01,8'h00}, // R7 port bit write
    {2'd0,1'b0,2'd0,8'h90,8'h00,8'h7F}, // R7
    {2'd3,1'b0,2'd0,8'h96,8'h00,8'h01}, // R7
    {2'd3,1'b0,2'd0,8'h97,8'h00,8'h00}, // R7
    {2'd2,1'b1,2'd3,8'h01,8'h22,8'h00}, // R4 bank3 R1 = 0x19
    {2'd1,1'b0,2'd3,8'h01,8'h00,8'h78}, // R3 via R1
    {2'd1,1'b1,2'd3,8'h01,8'hAA,8'h00}, // R3
    {2'd3,1'b0,2'd0,8'h10,8'h00,8'h00}, // R5
    {2'd3,1'b0,2'd0,8'h11,8'h00,8'h01}, // R5
    {2'd0,1'b0,2'd0,8'h19,8'h00,8'h22}, // R4
    {2'd0,1'b0,2'd0,8'h13,8'h00,8'hC3}  // R5 byte 0x13 not a bit target
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [1:0] k, input logic w, input logic [7:0] a);
    case (k)
      2'd0: return a[7] ? "R2" : "R1";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return a[7] ? "R7" : (w ? "R6" : "R5");
    endcase
  endfunction

  task automatic access(input logic [1:0] k, input logic w, input logic [1:0] b,
                        input logic [7:0] a, input logic [7:0] d,
                        output logic [7:0] rd, output int lat);
    @(negedge clk);
    req_kind = k; req_we = w; psw_bank = b; req_addr = a; req_wdata = d;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    rd  = 8'h00;
    if (!w) begin
      while (!rsp_valid && lat < 4) begin
        @(negedge clk);
        lat++;
      end
      rd = rsp_rdata;
    end else begin
      while (busy) @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    int lat;
    rst = 1'b1; req_valid = 1'b0; req_kind = 2'd0; req_addr = 8'h00;
    req_we = 1'b0; req_wdata = 8'h00; psw_bank = 2'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(busy == 1'b0 && rsp_valid == 1'b0, "R9 in reset", {busy, rsp_valid}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 1'b0 && rsp_valid == 1'b0 && sfr_re == 1'b0,
          "R9 after reset", {busy, rsp_valid, sfr_re}, 0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] k;
      logic       w;
      logic [7:0] a;
      logic [7:0] e;
      k = VEC[i][28:27];
      w = VEC[i][26];
      a = VEC[i][23:16];
      e = VEC[i][7:0];
      access(k, w, VEC[i][25:24], a, VEC[i][15:8], rd, lat);
      if (!w) begin
        check(rd == e, req_of(k, w, a), rd, e);
        check(lat == ((k == 2'd1) ? 2 : 1), "R10 latency", lat, (k == 2'd1) ? 2 : 1);
      end
    end

    // R6 and R8: bit write busy cycle, a request held during it is ignored
    @(negedge clk);
    req_kind = 2'd3; req_we = 1'b1; req_addr = 8'h13; req_wdata = 8'h00;
    psw_bank = 2'd0; req_valid = 1'b1;
    @(negedge clk);
    check(busy == 1'b1, "R6 busy in merge cycle", busy, 1);
    check(rsp_valid == 1'b0, "R10 no response to write", rsp_valid, 0);
    req_kind = 2'd0; req_addr = 8'h05; req_wdata = 8'hFF;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy == 1'b0, "R6 busy lasts one cycle", busy, 0);
    access(2'd0, 1'b0, 2'd0, 8'h05, 8'h00, rd, lat);
    check(rd == 8'hA5, "R8 request during busy ignored", rd, 8'hA5);
    access(2'd0, 1'b0, 2'd0, 8'h22, 8'h00, rd, lat);
    check(rd == 8'hA2, "R6 only bit3 of 0xAA cleared", rd, 8'hA2);

    // R3: indirect read through pointer 0x90 in bank 2 after bank changes
    access(2'd1, 1'b0, 2'd2, 8'h00, 8'h00, rd, lat);
    check(rd == 8'h3C, "R3 upper RAM after bank changes", rd, 8'h3C);
    check(lat == 2, "R10 indirect latency", lat, 2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule